// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Priority Resolver

This block gathers pending flags from a parameterised set of interrupt vectors and selects one of them to offer to the processor. Each vector has a software-programmed group level and a subpriority, plus an enable bit. Only the group level decides whether a request may interrupt the code the processor is running. The subpriority only orders requests that share a group level. A group level of zero takes the vector out of service completely. Such a vector neither interrupts nor wakes the processor.

Software programs the levels through a 32-bit register port. Each word holds the fields of four vectors. Every word can be written in three ways: as a plain write, as a clear alias that drops the bits written as one, or as a set alias that raises them. The processor supplies its current running level. The block answers with a registered request made of a valid bit, a vector number and the requested level, and with a wake-up indication. A two-state machine (`ST_IDLE`, `ST_REQUEST`) tracks whether a request is being offered. Both states move to `ST_REQUEST` when a selected vector beats the running level and back to `ST_IDLE` when none does.

Top module: `irq_pri_resolver`

## Requirements
- R1: After reset the request, wake-up, vector and level outputs are zero, all pending flags are clear and every priority word reads back as zero.
- R2: Vector v owns byte v%4 of word v/4. Within that byte, bits [4:2] hold the group level and bits [1:0] the subpriority. Bits [7:5] read as zero and ignore writes.
- R3: With `reg_op` 0 the addressed word takes the write data. With 1 each bit written as one is cleared. With 2 each bit written as one is set. With 3 the word is unchanged. Bits written as zero under 1 or 2 keep their value.
- R4: A pulse on `src_set` sets the pending flag at the next clock edge. The flag stays set until `flag_clr` is raised for it. When both are raised in the same cycle, the set wins.
- R5: A vector takes part in arbitration only when its flag is set, its enable is high and its group level is nonzero. A vector with group level zero raises neither a request nor a wake-up.
- R6: Among eligible vectors, the one with the highest group level is selected.
- R7: Among eligible vectors with equal group level, the one with the higher subpriority is selected.
- R8: When group level and subpriority both tie, the lowest-numbered vector is selected.
- R9: A request is offered only when the selected group level is strictly greater than `cpu_level`. An equal level never interrupts, whatever its subpriority.
- R10: While a request is offered, `req_vector` is the selected index and `req_level` is its group level. Otherwise both outputs are zero.
- R11: `wake_req` is high whenever any vector is eligible, whatever the value of `cpu_level`.
- R12: The outputs are registered. They reflect flags, registers and `cpu_level` as they were before the previous clock edge, so a source pulse shows up on the request two edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_set | input | NUM_VEC | Per-vector event pulses that set pending flags |
| flag_clr | input | NUM_VEC | Per-vector flag clear strobes |
| vec_enable | input | NUM_VEC | Per-vector enable |
| cpu_level | input | 3 | Processor's current running level |
| reg_wr | input | 1 | Register write strobe |
| reg_op | input | 2 | Write mode: 0 plain, 1 clear, 2 set, 3 none |
| reg_addr | input | ADDR_W | Word index for write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed word (combinational) |
| pend_flags | output | NUM_VEC | Current pending flags |
| req_valid | output | 1 | Request offered to the processor |
| req_vector | output | IDX_W | Selected vector number |
| req_level | output | 3 | Group level of the selected vector |
| wake_req | output | 1 | Wake-up indication |

## Verification
The hardest case to reach from the ports is a vector whose group level equals the running level but whose subpriority is the maximum. It must stay masked, and it must reappear once the level drops, because its flag was never cleared. The stimulus raises `cpu_level` to the flag's own group level, the way a service routine would. It checks that the request is gone while the wake-up stays high. It then lowers the level again without clearing the flag. A second hard case is a set pulse and a clear strobe landing on the same flag in the same cycle. The stimulus drives both in one cycle and reads `pend_flags` directly after the edge.

// File: rtl/irq_pri_pkg.sv
package irq_pri_pkg;

    localparam int GRP_W      = 3;
    localparam int SUB_W      = 2;
    localparam int FIELD_W    = GRP_W + SUB_W;
    localparam int SLOT_W     = 8;
    localparam int SLOTS_WORD = 4;
    localparam int WORD_W     = SLOT_W * SLOTS_WORD;

    typedef enum logic [1:0] {
        WR_PLAIN = 2'd0,
        WR_CLEAR = 2'd1,
        WR_SET   = 2'd2,
        WR_NONE  = 2'd3
    } wr_op_e;

    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_REQUEST = 1'b1
    } res_state_e;

endpackage

// File: rtl/irq_pri_regs.sv
module irq_pri_regs
    import irq_pri_pkg::*;
#(
    parameter int NUM_VEC = 8,
    parameter int ADDR_W  = 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [1:0]                 wr_op,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [WORD_W-1:0]          wr_data,
    output logic [WORD_W-1:0]          rd_data,
    output logic [NUM_VEC*FIELD_W-1:0] fields
);

    logic [FIELD_W-1:0] fld_q [NUM_VEC];

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_field
        localparam int WIDX  = v / SLOTS_WORD;
        localparam int SHIFT = (v % SLOTS_WORD) * SLOT_W;

        logic hit;
        logic [FIELD_W-1:0] din;

        assign hit = wr_en && (addr == ADDR_W'(WIDX));
        assign din = wr_data[SHIFT +: FIELD_W];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                fld_q[v] <= '0;
            end else if (hit) begin
                case (wr_op_e'(wr_op))
                    WR_PLAIN: fld_q[v] <= din;
                    WR_CLEAR: fld_q[v] <= fld_q[v] & ~din;
                    WR_SET:   fld_q[v] <= fld_q[v] | din;
                    default:  fld_q[v] <= fld_q[v];
                endcase
            end
        end

        assign fields[v*FIELD_W +: FIELD_W] = fld_q[v];
    end

    always_comb begin
        rd_data = '0;
        for (int v = 0; v < NUM_VEC; v++) begin
            if (addr == ADDR_W'(v / SLOTS_WORD)) begin
                rd_data[(v % SLOTS_WORD) * SLOT_W +: FIELD_W] = fld_q[v];
            end
        end
    end

endmodule

// File: rtl/irq_pri_flags.sv
module irq_pri_flags #(
    parameter int NUM_VEC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] set_i,
    input  logic [NUM_VEC-1:0] clr_i,
    output logic [NUM_VEC-1:0] flags
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= (flags & ~clr_i) | set_i;
        end
    end

endmodule

// File: rtl/irq_pri_arbiter.sv
module irq_pri_arbiter
    import irq_pri_pkg::*;
#(
    parameter int NUM_VEC = 8,
    parameter int IDX_W   = 3
) (
    input  logic [NUM_VEC-1:0]         flags,
    input  logic [NUM_VEC-1:0]         enable,
    input  logic [NUM_VEC*FIELD_W-1:0] fields,
    output logic                       win_valid,
    output logic [IDX_W-1:0]           win_idx,
    output logic [GRP_W-1:0]           win_grp
);

    logic [FIELD_W-1:0] best_key;

    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        best_key  = '0;
        for (int i = 0; i < NUM_VEC; i++) begin
            logic [FIELD_W-1:0] key;
            logic               elig;
            key  = fields[i*FIELD_W +: FIELD_W];
            elig = flags[i] && enable[i] && (key[FIELD_W-1 -: GRP_W] != '0);
            if (elig && (!win_valid || key > best_key)) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                best_key  = key;
            end
        end
        win_grp = best_key[FIELD_W-1 -: GRP_W];
    end

endmodule

// File: rtl/irq_pri_resolver.sv
module irq_pri_resolver
    import irq_pri_pkg::*;
#(
    parameter  int NUM_VEC   = 8,
    localparam int NUM_WORDS = (NUM_VEC + SLOTS_WORD - 1) / SLOTS_WORD,
    localparam int ADDR_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
    localparam int IDX_W     = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] src_set,
    input  logic [NUM_VEC-1:0] flag_clr,
    input  logic [NUM_VEC-1:0] vec_enable,
    input  logic [2:0]         cpu_level,
    input  logic               reg_wr,
    input  logic [1:0]         reg_op,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic [NUM_VEC-1:0] pend_flags,
    output logic               req_valid,
    output logic [IDX_W-1:0]   req_vector,
    output logic [2:0]         req_level,
    output logic               wake_req
);

    logic [NUM_VEC*FIELD_W-1:0] fields;
    logic                       win_valid;
    logic [IDX_W-1:0]           win_idx;
    logic [GRP_W-1:0]           win_grp;
    logic                       preempt_ok;

    res_state_e state_q, state_d;

    irq_pri_regs #(
        .NUM_VEC (NUM_VEC),
        .ADDR_W  (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wr_op   (reg_op),
        .addr    (reg_addr),
        .wr_data (reg_wdata),
        .rd_data (reg_rdata),
        .fields  (fields)
    );

    irq_pri_flags #(
        .NUM_VEC (NUM_VEC)
    ) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (src_set),
        .clr_i (flag_clr),
        .flags (pend_flags)
    );

    irq_pri_arbiter #(
        .NUM_VEC (NUM_VEC),
        .IDX_W   (IDX_W)
    ) u_arb (
        .flags     (pend_flags),
        .enable    (vec_enable),
        .fields    (fields),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_grp   (win_grp)
    );

    // Only the group level competes with the running level.
    assign preempt_ok = win_valid && (win_grp > cpu_level);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = preempt_ok ? ST_REQUEST : ST_IDLE;
            ST_REQUEST: state_d = preempt_ok ? ST_REQUEST : ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered outputs, updated on the same edge as the state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_vector <= '0;
            req_level  <= '0;
            wake_req   <= 1'b0;
        end else begin
            req_vector <= preempt_ok ? win_idx : '0;
            req_level  <= preempt_ok ? win_grp : '0;
            wake_req   <= win_valid;
        end
    end

    assign req_valid = (state_q == ST_REQUEST);

endmodule

// File: rtl/irq_pri_resolver_chk.sv
module irq_pri_resolver_chk #(
    parameter  int NUM_VEC = 8,
    localparam int IDX_W   = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [2:0]         cpu_level,
    input logic [NUM_VEC-1:0] flag_clr,
    input logic [NUM_VEC-1:0] pend_flags,
    input logic               req_valid,
    input logic [IDX_W-1:0]   req_vector,
    input logic [2:0]         req_level,
    input logic               wake_req
);

    logic [NUM_VEC-1:0] pend_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) pend_prev <= '0;
        else        pend_prev <= pend_flags;
    end

    // R9: a request beats the level the processor ran at one cycle earlier
    a_r9_strict_preempt: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_level > $past(cpu_level)));

    // R5: group level zero never reaches the request
    a_r5_level_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_level != 3'd0));

    // R10: outputs are zero while no request is offered
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (req_vector == '0 && req_level == 3'd0));

    // R11: any offered request implies a wake-up
    a_r11_wake_covers_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> wake_req);

    // R4: flags drop only when cleared
    a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(pend_flags) & ~$past(flag_clr) & ~pend_flags) == '0));

    // R12: the offered vector had its flag set before the previous edge
    a_r12_req_from_pending: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> pend_prev[req_vector]);

endmodule

bind irq_pri_resolver irq_pri_resolver_chk #(
    .NUM_VEC (NUM_VEC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_level  (cpu_level),
    .flag_clr   (flag_clr),
    .pend_flags (pend_flags),
    .req_valid  (req_valid),
    .req_vector (req_vector),
    .req_level  (req_level),
    .wake_req   (wake_req)
);

// File: tb/irq_pri_resolver_test.sv
module irq_pri_resolver_test;

    localparam int NV = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NV-1:0] src_set = '0;
    logic [NV-1:0] flag_clr = '0;
    logic [NV-1:0] vec_enable = '1;
    logic [2:0]    cpu_level = '0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_op = '0;
    logic [0:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NV-1:0] pend_flags;
    logic          req_valid;
    logic [2:0]    req_vector;
    logic [2:0]    req_level;
    logic          wake_req;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    irq_pri_resolver #(.NUM_VEC(NV)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_set    (src_set),
        .flag_clr   (flag_clr),
        .vec_enable (vec_enable),
        .cpu_level  (cpu_level),
        .reg_wr     (reg_wr),
        .reg_op     (reg_op),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .pend_flags (pend_flags),
        .req_valid  (req_valid),
        .req_vector (req_vector),
        .req_level  (req_level),
        .wake_req   (wake_req)
    );

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(string tag, logic v, logic [2:0] vec, logic [2:0] lvl, logic wk);
        chk(tag, "req_valid", 32'(req_valid), 32'(v));
        chk(tag, "req_vector", 32'(req_vector), 32'(vec));
        chk(tag, "req_level", 32'(req_level), 32'(lvl));
        chk(tag, "wake_req", 32'(wake_req), 32'(wk));
    endtask

    task automatic reg_write(logic [0:0] a, logic [1:0] op, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_op = op; reg_wdata = d;
        step(1);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic reg_read(logic [0:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic set_pri(int v, logic [2:0] g, logic [1:0] s);
        int sh;
        sh = (v % 4) * 8;
        reg_write(1'(v / 4), 2'd1, 32'h1F << sh);
        reg_write(1'(v / 4), 2'd2, 32'({g, s}) << sh);
    endtask

    task automatic pulse(logic [NV-1:0] m);
        src_set = m;
        step(1);
        src_set = '0;
    endtask

    task automatic clean();
        cpu_level = '0; vec_enable = '1; flag_clr = '1;
        step(1);
        flag_clr = '0;
        reg_write(1'b0, 2'd0, 32'h0);
        reg_write(1'b1, 2'd0, 32'h0);
        step(2);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        expect_out("R1", 1'b0, 3'd0, 3'd0, 1'b0);
        chk("R1", "pend_flags", 32'(pend_flags), 32'h0);
        reg_read(1'b0, d); chk("R1", "word0", d, 32'h0);
        reg_read(1'b1, d); chk("R1", "word1", d, 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        clean();
        reg_write(1'b0, 2'd0, 32'hFFFF_FFFF);
        reg_read(1'b0, d); chk("R2", "unused bits read zero", d, 32'h1F1F_1F1F);
        reg_read(1'b1, d); chk("R2", "other word untouched", d, 32'h0);
        reg_write(1'b0, 2'd1, 32'h0000_0003);
        reg_read(1'b0, d); chk("R3", "clear alias", d, 32'h1F1F_1F1C);
        reg_write(1'b0, 2'd2, 32'h0000_0001);
        reg_read(1'b0, d); chk("R3", "set alias", d, 32'h1F1F_1F1D);
        reg_write(1'b0, 2'd3, 32'h0);
        reg_read(1'b0, d); chk("R3", "op 3 no change", d, 32'h1F1F_1F1D);
        reg_write(1'b0, 2'd0, 32'h0000_1200);
        reg_read(1'b0, d); chk("R3", "plain write", d, 32'h0000_1200);
        set_pri(6, 3'd5, 2'd2);
        reg_read(1'b1, d); chk("R2", "vector 6 layout", d, 32'h0016_0000);
    endtask

    task automatic t_disabled();
        clean();
        pulse(8'h08);
        step(2);
        expect_out("R5", 1'b0, 3'd0, 3'd0, 1'b0);
        set_pri(3, 3'd2, 2'd0);
        step(2);
        expect_out("R5", 1'b1, 3'd3, 3'd2, 1'b1);
        vec_enable = 8'hF7;
        step(2);
        expect_out("R5", 1'b0, 3'd0, 3'd0, 1'b0);
    endtask

    task automatic t_group();
        clean();
        set_pri(1, 3'd3, 2'd3);
        set_pri(5, 3'd6, 2'd0);
        pulse(8'h22);
        step(2);
        expect_out("R6", 1'b1, 3'd5, 3'd6, 1'b1);
    endtask

    task automatic t_sub();
        clean();
        set_pri(2, 3'd4, 2'd1);
        set_pri(6, 3'd4, 2'd3);
        pulse(8'h44);
        step(2);
        expect_out("R7", 1'b1, 3'd6, 3'd4, 1'b1);
    endtask

    task automatic t_index();
        clean();
        set_pri(7, 3'd5, 2'd2);
        set_pri(4, 3'd5, 2'd2);
        pulse(8'h90);
        step(2);
        expect_out("R8", 1'b1, 3'd4, 3'd5, 1'b1);
    endtask

    task automatic t_preempt();
        clean();
        set_pri(0, 3'd3, 2'd3);
        pulse(8'h01);
        cpu_level = 3'd3;
        step(2);
        expect_out("R9", 1'b0, 3'd0, 3'd0, 1'b1);
        cpu_level = 3'd6;
        step(2);
        chk("R11", "wake above level", 32'(wake_req), 32'h1);
        cpu_level = 3'd2;
        step(2);
        expect_out("R10", 1'b1, 3'd0, 3'd3, 1'b1);
    endtask

    task automatic t_sticky();
        clean();
        set_pri(1, 3'd4, 2'd0);
        pulse(8'h02);
        step(2);
        expect_out("R4", 1'b1, 3'd1, 3'd4, 1'b1);
        cpu_level = 3'd4;
        step(2);
        expect_out("R4", 1'b0, 3'd0, 3'd0, 1'b1);
        cpu_level = 3'd0;
        step(2);
        expect_out("R4", 1'b1, 3'd1, 3'd4, 1'b1);
        flag_clr = 8'h02;
        step(1);
        flag_clr = '0;
        chk("R4", "flag cleared", 32'(pend_flags), 32'h0);
        step(2);
        expect_out("R4", 1'b0, 3'd0, 3'd0, 1'b0);
        src_set = 8'h02; flag_clr = 8'h02;
        step(1);
        src_set = '0; flag_clr = '0;
        chk("R4", "set wins over clear", 32'(pend_flags), 32'h02);
    endtask

    task automatic t_latency();
        clean();
        set_pri(2, 3'd5, 2'd0);
        step(1);
        src_set = 8'h04;
        step(1);
        src_set = '0;
        chk("R12", "flag after one edge", 32'(pend_flags), 32'h04);
        chk("R12", "no request yet", 32'(req_valid), 32'h0);
        step(1);
        expect_out("R12", 1'b1, 3'd2, 3'd5, 1'b1);
        cpu_level = 3'd5;
        chk("R12", "held before edge", 32'(req_valid), 32'h1);
        step(1);
        chk("R12", "dropped after edge", 32'(req_valid), 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        step(4);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_regs();
        t_disabled();
        t_group();
        t_sub();
        t_index();
        t_preempt();
        t_sticky();
        t_latency();
        summary();
        $finish;
    end

endmodule